// File: doc/BRIEF.md
# Dataflow Token Processor Controller

This block drives the execution unit of one processing stream in a dataflow machine. An upstream instruction stage presents a 56-bit instruction with a valid strobe. The controller takes it with a one-cycle acknowledge, spends a number of cycles set by the opcode on decoding and computing an 8-bit result, and then hands out up to two result tokens. Each token carries the result together with a destination address.

All tokens leave through a single output register. That register raises a request to a shared bus and holds its contents until the bus grant has been given and then removed. The acknowledge releases the upstream stage at once, so the next fetch runs alongside the current operation. Once the last token of an instruction sits in the output register, the controller goes back to accepting instructions without waiting for the bus transfer. A second token waits inside the controller for as long as the first one still holds the output register.

Top module: `token_proc_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, instr_ack and bus_req are 0.
- R2: instr_ack is high only when the controller is idle and instr_valid is high. The clock edge on which it is high loads the instruction. The instruction fields are: opcode [55:48], S1 [47:40], S2 [39:32], D1 [31:16], D2 [15:0].
- R3: Add (8'h01), subtract (8'h02), pass (8'h04) and any undefined opcode take 2 cycles, and multiply (8'h03) takes 13. With the output register empty, bus_req rises on the edge lat+1 edges after the accepting edge. instr_ack is never high on two consecutive cycles.
- R4: The token value is S1+S2, S1-S2, S1*S2 or S1, taken modulo 256.
- R5: Bit 15 of a destination field marks it valid. tok_dest carries bits [14:0] of that field.
- R6: When both destinations are valid, the D1 token leaves before the D2 token, and each carries the same value.
- R7: Loading a token raises bus_req, and the token stays stable while bus_req is high. bus_req stays high while bus_grant is high. It falls on the first edge at which bus_grant is seen low after being high.
- R8: The D2 token is not loaded while the output register still holds the D1 token. It is loaded on the edge after the register empties.
- R9: After its last token is loaded, the controller accepts the next instruction while that token still waits for the bus.
- R10: An instruction with neither destination valid completes without raising bus_req.
- R11: An undefined opcode completes in 2 cycles and produces no token, even when both destinations are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Upstream instruction available |
| instr_data | input | 56 | Instruction word |
| instr_ack | output | 1 | Instruction taken on this edge |
| bus_grant | input | 1 | Shared bus grant; its falling edge frees the output register |
| bus_req | output | 1 | Output register full, bus requested |
| tok_value | output | 8 | Token result value |
| tok_dest | output | 15 | Token destination address |

## Verification
Instructions are applied with one destination, two, or none, across all four operations plus an undefined opcode. The operand values include carries and borrows that wrap, and a multiply that overflows, so that modulo results can be told apart from wider ones. A short bus-grant delay checks the latency counts from acceptance to request for the short and the long operations. A long grant delay makes the second token stall behind the first and lets the next instruction be accepted while a token is still waiting. A per-cycle behavioural model compares the acknowledge and request timing on every clock, and a queue of expected tokens checks order, value and address at each grant.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam logic [7:0] OPC_ADD  = 8'h01;
  localparam logic [7:0] OPC_SUB  = 8'h02;
  localparam logic [7:0] OPC_MUL  = 8'h03;
  localparam logic [7:0] OPC_PASS = 8'h04;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_TOK1 = 2'd2,
    ST_TOK2 = 2'd3
  } tp_state_e;
endpackage

// File: rtl/tp_decode.sv
module tp_decode #(
  parameter int OP_W      = 8,
  parameter int CNT_W     = 4,
  parameter int LAT_SHORT = 2,
  parameter int LAT_MUL   = 13
) (
  input  logic [OP_W-1:0]  opcode,
  output logic [CNT_W-1:0] lat,
  output logic             defined
);
  import tp_pkg::*;
  always_comb begin
    lat     = CNT_W'(LAT_SHORT);
    defined = 1'b0;
    case (opcode[7:0])
      OPC_ADD, OPC_SUB, OPC_PASS: defined = 1'b1;
      OPC_MUL: begin
        defined = 1'b1;
        lat     = CNT_W'(LAT_MUL);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tp_alu.sv
module tp_alu #(
  parameter int OP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import tp_pkg::*;
  always_comb begin
    case (opcode[7:0])
      OPC_ADD:  y = a + b;
      OPC_SUB:  y = a - b;
      OPC_MUL:  y = a * b;
      OPC_PASS: y = a;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/tp_outreg.sv
module tp_outreg #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] value_in,
  input  logic [ADDR_W-1:0] dest_in,
  input  logic              bus_grant,
  output logic              busy,
  output logic [DATA_W-1:0] value_q,
  output logic [ADDR_W-1:0] dest_q
);
  logic grant_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      grant_q <= 1'b0;
      value_q <= '0;
      dest_q  <= '0;
    end else begin
      grant_q <= bus_grant;
      if (load) begin
        busy    <= 1'b1;
        value_q <= value_in;
        dest_q  <= dest_in;
      end else if (busy && grant_q && !bus_grant) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/token_proc_ctrl.sv
module token_proc_ctrl #(
  parameter int OP_W      = 8,
  parameter int DATA_W    = 8,
  parameter int DEST_W    = 16,
  parameter int LAT_SHORT = 2,
  parameter int LAT_MUL   = 13
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               instr_valid,
  input  logic [OP_W+2*DATA_W+2*DEST_W-1:0]  instr_data,
  output logic                               instr_ack,
  input  logic                               bus_grant,
  output logic                               bus_req,
  output logic [DATA_W-1:0]                  tok_value,
  output logic [DEST_W-2:0]                  tok_dest
);
  import tp_pkg::*;

  localparam int INSTR_W = OP_W + 2*DATA_W + 2*DEST_W;
  localparam int ADDR_W  = DEST_W - 1;
  localparam int LAT_MAX = (LAT_MUL > LAT_SHORT) ? LAT_MUL : LAT_SHORT;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam int OP_LSB  = INSTR_W - OP_W;
  localparam int S1_LSB  = OP_LSB - DATA_W;
  localparam int S2_LSB  = S1_LSB - DATA_W;
  localparam int D1_LSB  = DEST_W;

  tp_state_e           state;
  logic [OP_W-1:0]     op_q;
  logic [DATA_W-1:0]   s1_q, s2_q, res_q;
  logic [DEST_W-1:0]   d1_q, d2_q;
  logic                ok_q;
  logic [CNT_W-1:0]    cnt_q;

  logic [CNT_W-1:0]    new_lat;
  logic                new_ok;
  logic [DATA_W-1:0]   alu_y;
  logic                busy, load;
  logic [DATA_W-1:0]   ld_value;
  logic [ADDR_W-1:0]   ld_dest;

  tp_decode #(.OP_W(OP_W), .CNT_W(CNT_W), .LAT_SHORT(LAT_SHORT), .LAT_MUL(LAT_MUL)) i_dec (
    .opcode  (instr_data[INSTR_W-1:OP_LSB]),
    .lat     (new_lat),
    .defined (new_ok)
  );

  tp_alu #(.OP_W(OP_W), .DATA_W(DATA_W)) i_alu (
    .opcode (op_q),
    .a      (s1_q),
    .b      (s2_q),
    .y      (alu_y)
  );

  assign instr_ack = (state == ST_IDLE) && instr_valid;
  assign load      = ((state == ST_TOK1) || (state == ST_TOK2)) && !busy;
  assign ld_value  = res_q;
  assign ld_dest   = (state == ST_TOK2) ? d2_q[ADDR_W-1:0] : d1_q[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      op_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      d1_q  <= '0;
      d2_q  <= '0;
      ok_q  <= 1'b0;
      cnt_q <= '0;
      res_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (instr_valid) begin
          op_q  <= instr_data[INSTR_W-1:OP_LSB];
          s1_q  <= instr_data[OP_LSB-1:S1_LSB];
          s2_q  <= instr_data[S1_LSB-1:S2_LSB];
          d1_q  <= instr_data[S2_LSB-1:D1_LSB];
          d2_q  <= instr_data[DEST_W-1:0];
          ok_q  <= new_ok;
          cnt_q <= new_lat;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (cnt_q == CNT_W'(1)) begin
            res_q <= alu_y;
            if (!ok_q)                state <= ST_IDLE;
            else if (d1_q[DEST_W-1])  state <= ST_TOK1;
            else if (d2_q[DEST_W-1])  state <= ST_TOK2;
            else                      state <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_TOK1: if (!busy) state <= d2_q[DEST_W-1] ? ST_TOK2 : ST_IDLE;
        ST_TOK2: if (!busy) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  tp_outreg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .value_in  (ld_value),
    .dest_in   (ld_dest),
    .bus_grant (bus_grant),
    .busy      (busy),
    .value_q   (tok_value),
    .dest_q    (tok_dest)
  );

  assign bus_req = busy;
endmodule

// File: rtl/token_proc_ctrl_chk.sv
module token_proc_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              instr_ack,
  input logic              bus_grant,
  input logic              bus_req,
  input logic [DATA_W-1:0] tok_value,
  input logic [ADDR_W-1:0] tok_dest
);
  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    instr_ack |-> instr_valid); // R2

  AST_ACK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    instr_ack |=> !instr_ack); // R3

  AST_REQ_HELD_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_grant) |=> bus_req); // R7

  AST_TOKEN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req)) |-> ($stable(tok_value) && $stable(tok_dest))); // R7

  AST_REQ_DROP_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_grant) && bus_req) |=> !bus_req); // R7
endmodule

bind token_proc_ctrl token_proc_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(DEST_W-1)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_ack   (instr_ack),
  .bus_grant   (bus_grant),
  .bus_req     (bus_req),
  .tok_value   (tok_value),
  .tok_dest    (tok_dest)
);

// File: tb/test_token_proc_ctrl.sv
`timescale 1ns/100ps
module test_token_proc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [55:0] instr_data = '0;
  logic        instr_ack;
  logic        bus_grant = 1'b0;
  logic        bus_req;
  logic [7:0]  tok_value;
  logic [14:0] tok_dest;

  int checks = 0;
  int fails  = 0;
  int gdly   = 1;
  logic ack_busy = 1'b0;
  logic [22:0] exp_q[$];

  always #2.5 clk = ~clk;

  token_proc_ctrl i_token_proc_ctrl (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_data(instr_data),
    .instr_ack(instr_ack), .bus_grant(bus_grant), .bus_req(bus_req),
    .tok_value(tok_value), .tok_dest(tok_dest)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_val(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      8'h01: return a + b;
      8'h02: return a - b;
      8'h03: return a * b;
      8'h04: return a;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit op_defined(input logic [7:0] op);
    return (op >= 8'h01) && (op <= 8'h04);
  endfunction

  // behavioural timing model
  int m_st = 0, m_cnt = 0;
  bit m_ok, m_d1, m_d2, m_busy, m_gq;
  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_busy = 0; m_gq = 0;
    end else begin
      bit nb;
      nb = m_busy;
      if (m_busy && m_gq && !bus_grant) nb = 0;
      case (m_st)
        0: if (instr_valid) begin
             m_ok  = op_defined(instr_data[55:48]);
             m_d1  = instr_data[31];
             m_d2  = instr_data[15];
             m_cnt = (instr_data[55:48] == 8'h03) ? 13 : 2;
             m_st  = 1;
           end
        1: if (m_cnt == 1) m_st = !m_ok ? 0 : m_d1 ? 2 : m_d2 ? 3 : 0;
           else m_cnt--;
        2: if (!m_busy) begin nb = 1; m_st = m_d2 ? 3 : 0; end
        default: if (!m_busy) begin nb = 1; m_st = 0; end
      endcase
      m_gq = bus_grant;
      m_busy = nb;
    end
  end

  always @(negedge clk) if (!rst) begin
    chk(instr_ack == ((m_st == 0) && instr_valid), "R2 ack timing", instr_ack, (m_st == 0) && instr_valid);
    chk(bus_req == m_busy, "R7 R8 bus_req timing", bus_req, m_busy);
  end

  // bus grantor
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !rst) begin
        repeat (gdly) @(negedge clk);
        @(posedge clk); #1 bus_grant = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected token", tok_value, 0);
        else begin
          logic [22:0] e;
          e = exp_q.pop_front();
          chk(tok_value == e[22:15], "R4 token value", tok_value, e[22:15]);
          chk(tok_dest == e[14:0], "R5 R6 token dest", tok_dest, e[14:0]);
        end
        bus_grant = 1'b0;
        @(negedge clk);
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [15:0] d1, input logic [15:0] d2, input int exp_lat);
    @(posedge clk); #1;
    instr_valid = 1'b1;
    instr_data  = {op, a, b, d1, d2};
    do @(negedge clk); while (!instr_ack);
    ack_busy = bus_req;
    if (op_defined(op)) begin
      if (d1[15]) exp_q.push_back({ref_val(op, a, b), d1[14:0]});
      if (d2[15]) exp_q.push_back({ref_val(op, a, b), d2[14:0]});
    end
    @(posedge clk); #1 instr_valid = 1'b0;
    if (exp_lat > 0) begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!bus_req && n < 40);
      chk(n == exp_lat, "R3 latency", n, exp_lat);
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || bus_req) && n < 500) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!instr_ack && !bus_req, "R1 outputs in reset", {instr_ack, bus_req}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(!instr_ack && !bus_req, "R1 outputs after reset", {instr_ack, bus_req}, 0);
    repeat (4) @(negedge clk);
    chk(!instr_ack, "R2 no ack without valid", instr_ack, 0);

    gdly = 1;
    send(8'h01, 8'd10, 8'd20, 16'h8123, 16'h0000, 4);   // R3 short: lat 2 + 2
    drain();
    send(8'h03, 8'd13, 8'd11, 16'h8042, 16'h0000, 15);  // R3 mul: lat 13 + 2
    drain();
    send(8'h02, 8'd5, 8'd9, 16'h8001, 16'hFFFF, 0);     // R4 borrow, R6 two tokens
    send(8'h04, 8'hA5, 8'h00, 16'h0000, 16'h8077, 0);   // R5 D2 only
    send(8'h03, 8'd200, 8'd3, 16'h8555, 16'h8666, 0);   // R4 overflow
    send(8'h01, 8'd250, 8'd10, 16'hFFFE, 16'h0000, 0);  // R4 wrap
    drain();

    gdly = 12;
    send(8'h01, 8'd1, 8'd2, 16'h8010, 16'h8020, 0);     // R8 second token stalls
    send(8'h02, 8'd50, 8'd8, 16'h8030, 16'h0000, 0);
    send(8'h04, 8'd77, 8'd0, 16'h8040, 16'h0000, 0);
    chk(ack_busy == 1'b1, "R9 ack while token waits", ack_busy, 1);
    drain();

    gdly = 2;
    send(8'h01, 8'd3, 8'd4, 16'h0011, 16'h0022, 0);     // R10
    repeat (20) @(negedge clk);
    chk(!bus_req && exp_q.size() == 0, "R10 no token without destinations", bus_req, 0);
    send(8'h7F, 8'd3, 8'd4, 16'h8011, 16'h8022, 0);     // R11
    repeat (20) @(negedge clk);
    chk(!bus_req && exp_q.size() == 0, "R11 undefined opcode no token", bus_req, 0);
    send(8'h04, 8'h3C, 8'd0, 16'h8100, 16'h0000, 0);
    drain();
    chk(exp_q.size() == 0, "R6 all tokens delivered", exp_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule